// File: doc/BRIEF.md
# Multi-Bank RAM Sweep-Clear and Check-Bit Controller

This block sits in front of four RAM banks and owns their write ports. Software drives a single 32-bit control word. Each bank has two controls in that word. The first is a self-clearing trigger. It launches a sweep that writes zero data to every address of the bank. Each of those writes carries the check bits that match the location's address. The second control is a test enable. While it is set, check-bit generation and checking for that bank are bypassed, so raw data and check bits can be stored.

Outside a sweep, each bank takes functional writes through a valid/ready port. A write is accepted in any cycle where both `fn_valid` and `fn_ready` are high. `fn_ready` drops for a bank while that bank sweeps, so the sweep always wins. The source must hold its request until ready returns. The block has no storage of its own on this path: an accepted write goes straight out on the RAM write port in the same cycle. The RAM arrays, the read-side error reporting and interrupts live elsewhere. `ecc_bypass` tells the read-side checker which banks are in test mode.

Top module: `ram_init_ctrl`

## Requirements
- R1: After reset, `reg_rd_data` reads 0, no bank is busy, no bank is in test mode, and no `ram_we` bit is high while no functional request is pending.
- R2: Bank n's test enable is control bit 2n+1, and it reads back the value last written. Bank n's trigger is bit 2n, and it always reads 0. Bits 31..8 always read 0.
- R3: A register write with bit 2n = 1 to an idle bank n raises `busy[n]` in the next cycle. `busy[n]` then stays high for exactly DEPTH cycles. A write with bit 2n = 0 starts nothing.
- R4: While `busy[n]` is high, bank n's RAM port writes once per cycle. The addresses run 0, 1, …, DEPTH-1 in order, the data is 0, and the check bits are the R5 code of zero data at that address.
- R5: The check code has CHK_W bits. Check bit i is the even parity of two groups of bits: the data bits j with j mod CHK_W = i, and the address bits j with (DATA_W+j) mod CHK_W = i. With the defaults, zero data at address a gives check bits equal to a.
- R6: A trigger for a bank that is already busy is ignored. The running sweep neither restarts nor gets longer.
- R7: Sweeps on different banks run independently and may overlap in time.
- R8: While `busy[n]` is high, `fn_ready[n]` is 0, and functional data never reaches bank n's RAM port.
- R9: When bank n is idle and not in test mode, a functional write drives `ram_we[n]` in the same cycle. It passes the address and data through unchanged and writes check bits generated per R5.
- R10: While bank n's test enable is 1, `ecc_bypass[n]` is 1, and a functional write stores the supplied `fn_chk` bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wr_data | input | 32 | Control register write value |
| reg_rd_data | output | 32 | Control register read value |
| fn_valid | input | NBANK | Per-bank functional write request |
| fn_ready | output | NBANK | Per-bank functional write acceptance (low while sweeping) |
| fn_addr | input | NBANK*ADDR_W | Per-bank functional address, bank n at [n*ADDR_W +: ADDR_W] |
| fn_data | input | NBANK*DATA_W | Per-bank functional data |
| fn_chk | input | NBANK*CHK_W | Per-bank raw check bits, used in test mode |
| ram_we | output | NBANK | Per-bank RAM write enable |
| ram_addr | output | NBANK*ADDR_W | Per-bank RAM address |
| ram_wdata | output | NBANK*DATA_W | Per-bank RAM write data |
| ram_wchk | output | NBANK*CHK_W | Per-bank RAM check bits |
| busy | output | NBANK | Per-bank sweep in progress |
| ecc_bypass | output | NBANK | Per-bank test mode, for the read-side checker |

## Verification
The bench walks a full sweep cycle by cycle while a functional write pushes on the same bank. A design that let the request through, skipped or repeated an address, or stored check bits that ignore the address would fail here. A second trigger arrives mid-sweep, which catches a design that restarts or stretches the sweep. A second bank is started while the first is still running, which catches shared counters. Functional writes are checked with and without test mode, which exposes a mux that regenerates the check bits when it should pass them through. Readback checks that trigger bits and reserved bits stay zero even after all ones has been written.

// File: rtl/ric_pkg.sv
package ric_pkg;
  localparam int REG_W    = 32;
  localparam int BANK_MAX = 16;
endpackage

// File: rtl/ric_ctrl_reg.sv
module ric_ctrl_reg #(
  parameter int NBANK = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [2*NBANK-1:0]     wr_bits,
  output logic [NBANK-1:0]       start,
  output logic [NBANK-1:0]       test_en,
  output logic [ric_pkg::REG_W-1:0] rd_data
);
  localparam int RW = ric_pkg::REG_W;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign start[b] = wr_en & wr_bits[2*b];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     test_en[b] <= 1'b0;
      else if (wr_en) test_en[b] <= wr_bits[2*b+1];
    end
  end

  always_comb begin
    rd_data = '0;
    for (int b = 0; b < NBANK; b++) rd_data[2*b+1] = test_en[b];
  end
endmodule

// File: rtl/ric_sweeper.sv
module ric_sweeper #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] LAST = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      addr <= '0;
    end else if (busy) begin
      if (addr == LAST) begin
        busy <= 1'b0;
        addr <= '0;
      end else begin
        addr <= addr + 1'b1;
      end
    end else if (start) begin
      busy <= 1'b1;
      addr <= '0;
    end
  end
endmodule

// File: rtl/ric_chk_gen.sv
module ric_chk_gen #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int CHK_W  = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic [ADDR_W-1:0] addr,
  output logic [CHK_W-1:0]  chk
);
  localparam int TOT = DATA_W + ADDR_W;
  localparam int NSL = (TOT + CHK_W - 1) / CHK_W;

  logic [NSL*CHK_W-1:0] padded;

  always_comb begin
    padded = '0;
    padded[TOT-1:0] = {addr, data};
    chk = '0;
    for (int s = 0; s < NSL; s++) chk = chk ^ padded[s*CHK_W +: CHK_W];
  end
endmodule

// File: rtl/ric_port_mux.sv
module ric_port_mux #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int CHK_W  = 8
) (
  input  logic              sweep_busy,
  input  logic [ADDR_W-1:0] sweep_addr,
  input  logic              test_en,
  input  logic              fn_valid,
  input  logic [ADDR_W-1:0] fn_addr,
  input  logic [DATA_W-1:0] fn_data,
  input  logic [CHK_W-1:0]  fn_chk,
  output logic              fn_ready,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic [CHK_W-1:0]  ram_wchk
);
  logic [CHK_W-1:0] gen_chk;

  assign fn_ready  = ~sweep_busy;
  assign ram_we    = sweep_busy | fn_valid;
  assign ram_addr  = sweep_busy ? sweep_addr : fn_addr;
  assign ram_wdata = sweep_busy ? '0 : fn_data;

  ric_chk_gen #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CHK_W(CHK_W)) u_gen (
    .data (ram_wdata),
    .addr (ram_addr),
    .chk  (gen_chk)
  );

  assign ram_wchk = (!sweep_busy && test_en) ? fn_chk : gen_chk;
endmodule

// File: rtl/ram_init_ctrl.sv
module ram_init_ctrl #(
  parameter int NBANK  = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int CHK_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_wr_en,
  input  logic [31:0]               reg_wr_data,
  output logic [31:0]               reg_rd_data,
  input  logic [NBANK-1:0]          fn_valid,
  output logic [NBANK-1:0]          fn_ready,
  input  logic [NBANK*ADDR_W-1:0]   fn_addr,
  input  logic [NBANK*DATA_W-1:0]   fn_data,
  input  logic [NBANK*CHK_W-1:0]    fn_chk,
  output logic [NBANK-1:0]          ram_we,
  output logic [NBANK*ADDR_W-1:0]   ram_addr,
  output logic [NBANK*DATA_W-1:0]   ram_wdata,
  output logic [NBANK*CHK_W-1:0]    ram_wchk,
  output logic [NBANK-1:0]          busy,
  output logic [NBANK-1:0]          ecc_bypass
);
  localparam int CTRL_W = 2 * NBANK;

  logic [NBANK-1:0] start;
  logic [NBANK-1:0] test_en;
  logic             unused_hi;

  assign unused_hi = ^reg_wr_data[31:CTRL_W];

  ric_ctrl_reg #(.NBANK(NBANK)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr_en),
    .wr_bits (reg_wr_data[CTRL_W-1:0]),
    .start   (start),
    .test_en (test_en),
    .rd_data (reg_rd_data)
  );

  assign ecc_bypass = test_en;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [ADDR_W-1:0] sw_addr;

    ric_sweeper #(.ADDR_W(ADDR_W)) u_sweep (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start[b]),
      .busy  (busy[b]),
      .addr  (sw_addr)
    );

    ric_port_mux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CHK_W(CHK_W)) u_mux (
      .sweep_busy (busy[b]),
      .sweep_addr (sw_addr),
      .test_en    (test_en[b]),
      .fn_valid   (fn_valid[b]),
      .fn_addr    (fn_addr[b*ADDR_W +: ADDR_W]),
      .fn_data    (fn_data[b*DATA_W +: DATA_W]),
      .fn_chk     (fn_chk[b*CHK_W +: CHK_W]),
      .fn_ready   (fn_ready[b]),
      .ram_we     (ram_we[b]),
      .ram_addr   (ram_addr[b*ADDR_W +: ADDR_W]),
      .ram_wdata  (ram_wdata[b*DATA_W +: DATA_W]),
      .ram_wchk   (ram_wchk[b*CHK_W +: CHK_W])
    );
  end
endmodule

// File: rtl/ric_checker.sv
module ric_checker #(
  parameter int NBANK  = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int CHK_W  = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    reg_wr_en,
  input logic [31:0]             reg_wr_data,
  input logic [31:0]             reg_rd_data,
  input logic [NBANK-1:0]        fn_valid,
  input logic [NBANK-1:0]        fn_ready,
  input logic [NBANK*ADDR_W-1:0] fn_addr,
  input logic [NBANK-1:0]        ram_we,
  input logic [NBANK*ADDR_W-1:0] ram_addr,
  input logic [NBANK*DATA_W-1:0] ram_wdata,
  input logic [NBANK-1:0]        busy
);
  logic [31:0] zero_mask;
  always_comb begin
    zero_mask = '1;
    for (int b = 0; b < NBANK; b++) zero_mask[2*b+1] = 1'b0;
  end

  assert_regrd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_data & zero_mask) == 32'd0);

  for (genvar b = 0; b < NBANK; b++) begin : g_chk
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy[b] && !fn_valid[b]) |-> !ram_we[b]);

    assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && reg_wr_data[2*b] && !busy[b]) |=> busy[b]);

    assert_sweep_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy[b]) |-> (ram_we[b] && ram_addr[b*ADDR_W +: ADDR_W] == '0
                          && ram_wdata[b*DATA_W +: DATA_W] == '0));

    assert_sweep_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy[b] && $past(busy[b])) |->
        ram_addr[b*ADDR_W +: ADDR_W] == $past(ram_addr[b*ADDR_W +: ADDR_W]) + 1'b1);

    assert_sweep_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy[b] |-> (!fn_ready[b] && ram_wdata[b*DATA_W +: DATA_W] == '0));

    assert_fn_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (fn_valid[b] && fn_ready[b]) |->
        (ram_we[b] && ram_addr[b*ADDR_W +: ADDR_W] == fn_addr[b*ADDR_W +: ADDR_W]));
  end
endmodule

bind ram_init_ctrl ric_checker #(
  .NBANK(NBANK), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHK_W(CHK_W)
) u_ric_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr_en   (reg_wr_en),
  .reg_wr_data (reg_wr_data),
  .reg_rd_data (reg_rd_data),
  .fn_valid    (fn_valid),
  .fn_ready    (fn_ready),
  .fn_addr     (fn_addr),
  .ram_we      (ram_we),
  .ram_addr    (ram_addr),
  .ram_wdata   (ram_wdata),
  .busy        (busy)
);

// File: tb/tb_ram_init_ctrl.sv
module tb_ram_init_ctrl;
  localparam int PERIOD = 10;
  localparam int NB = 4;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam int CW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr_en = 1'b0;
  logic [31:0] reg_wr_data = '0;
  logic [31:0] reg_rd_data;
  logic [NB-1:0] fn_valid = '0;
  logic [NB-1:0] fn_ready;
  logic [NB*AW-1:0] fn_addr = '0;
  logic [NB*DW-1:0] fn_data = '0;
  logic [NB*CW-1:0] fn_chk = '0;
  logic [NB-1:0] ram_we;
  logic [NB*AW-1:0] ram_addr;
  logic [NB*DW-1:0] ram_wdata;
  logic [NB*CW-1:0] ram_wchk;
  logic [NB-1:0] busy;
  logic [NB-1:0] ecc_bypass;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  ram_init_ctrl #(.NBANK(NB), .ADDR_W(AW), .DATA_W(DW), .CHK_W(CW)) dut (.*);

  // {bank, test, addr, data, raw chk}
  localparam logic [46:0] VEC [8] = '{
    {2'd0, 1'b0, 4'd3,  32'h1234_5678, 8'h00},
    {2'd1, 1'b0, 4'd15, 32'hFFFF_FFFF, 8'hAA},
    {2'd2, 1'b0, 4'd0,  32'h0000_0001, 8'h00},
    {2'd3, 1'b0, 4'd9,  32'hA5A5_0F0F, 8'h11},
    {2'd0, 1'b1, 4'd5,  32'hCAFE_F00D, 8'h3C},
    {2'd1, 1'b1, 4'd7,  32'h0000_0000, 8'hFF},
    {2'd2, 1'b1, 4'd12, 32'h8000_0000, 8'h81},
    {2'd3, 1'b1, 4'd1,  32'h5555_AAAA, 8'h00}
  };

  function automatic logic [CW-1:0] ref_chk(logic [DW-1:0] d, logic [AW-1:0] a);
    logic [CW-1:0] c = '0;
    for (int j = 0; j < DW; j++) c[j % CW] ^= d[j];
    for (int j = 0; j < AW; j++) c[(DW + j) % CW] ^= a[j];
    return c;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [31:0] v);
    @(negedge clk);
    reg_wr_en = 1'b1;
    reg_wr_data = v;
    @(negedge clk);
    reg_wr_en = 1'b0;
    reg_wr_data = '0;
    #1;
  endtask

  task automatic wait_idle();
    while (busy != '0) @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    check("R1 rd", reg_rd_data, 0);
    check("R1 busy", busy, 0);
    check("R1 we", ram_we, 0);
    check("R1 bypass", ecc_bypass, 0);

    // R3: writing zeros starts nothing
    reg_write(32'h0);
    @(negedge clk); #1;
    check("R3 zero write busy", busy, 0);
    check("R3 zero write we", ram_we, 0);

    // R9 / R10: vector walk of functional writes
    for (int i = 0; i < 8; i++) begin
      logic [1:0] bk;
      logic tm;
      logic [AW-1:0] ad;
      logic [DW-1:0] dt;
      logic [CW-1:0] ck;
      {bk, tm, ad, dt, ck} = VEC[i];
      reg_write(32'(tm) << (2*bk + 1));
      fn_valid[bk] = 1'b1;
      fn_addr[bk*AW +: AW] = ad;
      fn_data[bk*DW +: DW] = dt;
      fn_chk[bk*CW +: CW] = ck;
      #1;
      check("R9 ready", fn_ready[bk], 1);
      check("R9 we", ram_we, 64'(1) << bk);
      check("R9 addr", ram_addr[bk*AW +: AW], ad);
      check("R9 data", ram_wdata[bk*DW +: DW], dt);
      check(tm ? "R10 raw chk" : "R5 gen chk", ram_wchk[bk*CW +: CW], tm ? ck : ref_chk(dt, ad));
      check("R10 bypass", ecc_bypass, 64'(tm) << bk);
      @(negedge clk);
      fn_valid = '0;
    end

    // R2: readback of test bits; triggers and reserved read zero
    reg_write(32'h0000_0022);
    check("R2 read tm", reg_rd_data, 32'h22);
    reg_write(32'hFFFF_FFFF);
    check("R2 read all ones", reg_rd_data, 32'hAA);
    check("R7 all busy", busy, 4'hF);
    wait_idle();
    check("R2 read after sweep", reg_rd_data, 32'hAA);
    reg_write(32'h0);

    // R4 / R8 / R3: full sweep of bank 2 against a pending functional write
    reg_write(32'h10);
    fn_valid[2] = 1'b1;
    fn_data[2*DW +: DW] = 32'hDEAD_BEEF;
    fn_addr[2*AW +: AW] = 4'd7;
    for (int k = 0; k < DEPTH; k++) begin
      #1;
      check("R3 busy", busy, 4'b0100);
      check("R8 ready low", fn_ready[2], 0);
      check("R4 we", ram_we[2], 1);
      check("R4 addr", ram_addr[2*AW +: AW], k);
      check("R8 data zero", ram_wdata[2*DW +: DW], 0);
      check("R5 sweep chk", ram_wchk[2*CW +: CW], ref_chk('0, AW'(k)));
      @(negedge clk);
    end
    #1;
    check("R3 busy ends", busy, 0);
    check("R8 ready back", fn_ready[2], 1);
    fn_valid = '0;

    // R6: retrigger mid-sweep is ignored
    reg_write(32'h1);
    repeat (4) @(negedge clk);
    reg_write(32'h1);
    check("R6 no restart", ram_addr[0 +: AW], 6);
    repeat (DEPTH - 7) @(negedge clk);
    #1;
    check("R6 last addr", ram_addr[0 +: AW], DEPTH - 1);
    check("R6 still busy", busy[0], 1);
    @(negedge clk); #1;
    check("R6 ends on time", busy[0], 0);

    // R7: overlapping sweeps on banks 0 and 1
    reg_write(32'h1);
    @(negedge clk);
    reg_write(32'h4);
    check("R7 bank0 addr", ram_addr[0 +: AW], 3);
    check("R7 bank1 addr", ram_addr[AW +: AW], 0);
    check("R7 both busy", busy, 4'b0011);
    wait_idle();
    check("R7 idle", busy, 0);

    finish_run();
  end
endmodule